// File: doc/BRIEF.md
# Interrupt Source Gating and Routing

This block holds the settings of a bank of interrupt sources and turns changes on their input lines into pending requests for one or more processors. Each source has two 32-bit registers. The configuration register holds the mask, the polarity, the sense, the priority and the vector. The target register holds one enable bit per processor. Both registers are written and read through a small register port selected by source number and register select.

A change on a source input is an event. The block checks the event against the source's mask, its priority, its targets and its current activity. When the event passes, the block offers the request to every enabled processor. A processor accepts the request only if the source priority is strictly above that processor's task priority and the source is not already pending for it. Acceptance sets the source's bit in that processor's pending set and sets the source's activity flag. If an accepted request outranks everything already pending for that processor, the processor's interrupt line pulses.

Acknowledge and end-of-interrupt handling are outside this block. That logic clears activity through `act_clr` and pending bits through `raised_clr`.

Top module: `irq_src_router`

## Requirements
- R1: After reset, every configuration register reads 0xA0000000, every target register reads 0, all pending bits are 0 and every `cpu_irq` line is low.
- R2: Configuration register bits:
  - Bit 31 (mask), bits 19:16 (priority) and bits 7:0 (vector) are writable for every source.
  - Bits 23:22 are also writable for sources below FIRST_TMR.
  - Bits 23:20 are also writable for sources at or above FIRST_TMR.
  - All other bits read 0 after a write.
  - Bit 30 reads the activity flag, and a write never changes it.
- R3: A write to a target register keeps bits 31:30 and bits NCPU-1:0; all other bits read 0.
- R4: An event is a clock edge at which `irq_in[s]` differs from the value sampled at the previous edge. The input counts as asserted when it equals bit 23 (1 = active high, 0 = active low). Bit 22 set makes the source level-sensitive; bit 22 clear makes it edge-sensitive.
- R5: An event is ignored when bit 31 (mask) is 1, when the priority is 0, or when the whole target register is 0.
- R6: A deasserting event on an active level-sensitive source clears its activity flag and changes nothing else. A deasserting event on an edge-sensitive source has no effect.
- R7: An asserting event on a source whose activity flag is set is ignored.
- R8: An asserting event delivers the request to processor c when all of these hold:
  - target bit c is set;
  - the source priority is strictly greater than `task_pri[4c+3:4c]`;
  - pending bit `raised_o[c*NSRC+s]` is 0.
  Delivery sets that pending bit and the activity flag. If no processor accepts, activity stays 0.
- R9: `cpu_irq[c]` is high for exactly the one cycle after an event edge at which processor c accepted a request whose priority exceeds the highest priority pending for c before that edge (0 when nothing was pending).
- R10: `act_clr[s]` clears the activity flag of source s, and `raised_clr` clears the matching pending bits. A delivery in the same cycle wins over either clear.
- R11: An event is judged with the register contents from before a register write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | NSRC | Source input lines, synchronous to clk |
| task_pri | input | 4*NCPU | Task priority per processor, 4 bits each |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | $clog2(NSRC) | Source number for the access |
| reg_sel | input | 1 | 0 = configuration register, 1 = target register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register, combinational |
| act_clr | input | NSRC | Per-source activity clear pulse |
| raised_clr | input | NCPU*NSRC | Per-processor, per-source pending clear pulse |
| raised_o | output | NCPU*NSRC | Pending sets, processor c at bits c*NSRC+NSRC-1 : c*NSRC |
| cpu_irq | output | NCPU | One-cycle interrupt pulse per processor |

## Verification
The assertions take three things for granted about the inputs:
- `irq_in` is already synchronous to `clk`.
- `reg_idx` always names an existing source.
- The ranking of task priorities against source priorities changes only between edges.

The stimulus keeps within these limits. It changes every input only on the falling edge, issues at most one register write per cycle, and keeps the index below NSRC. Each event is held for at least one full cycle, so every change counts as exactly one event.

// File: rtl/ipr_pkg.sv
package ipr_pkg;
  localparam int PRI_W     = 4;
  localparam int PRI_LSB   = 16;
  localparam int MASK_BIT  = 31;
  localparam int ACT_BIT   = 30;
  localparam int POL_BIT   = 23;
  localparam int SENSE_BIT = 22;

  localparam logic [31:0] CFG_RST     = 32'hA000_0000;
  localparam logic [31:0] CFG_WM_ALL  = 32'h800F_00FF;
  localparam logic [31:0] CFG_WM_EXT  = 32'h00C0_0000;
  localparam logic [31:0] CFG_WM_TMR  = 32'h00F0_0000;
  localparam logic [31:0] DST_KEEP    = 32'hC000_0000;

  localparam logic SEL_CFG = 1'b0;
  localparam logic SEL_DST = 1'b1;
endpackage

// File: rtl/ipr_src_regs.sv
module ipr_src_regs
  import ipr_pkg::*;
#(
  parameter int NSRC      = 16,
  parameter int NCPU      = 2,
  parameter int FIRST_TMR = 12,
  localparam int SW       = $clog2(NSRC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] idx,
  input  logic          sel,
  input  logic [31:0]   wdata,
  output logic [31:0]   cfg [NSRC],
  output logic [31:0]   dst [NSRC]
);
  localparam logic [31:0] DST_WM = DST_KEEP | 32'((64'd1 << NCPU) - 64'd1);

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    localparam logic [31:0] WM = CFG_WM_ALL | ((s >= FIRST_TMR) ? CFG_WM_TMR : CFG_WM_EXT);
    logic hit;
    assign hit = we && (idx == SW'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg[s] <= CFG_RST;
        dst[s] <= '0;
      end else if (hit) begin
        if (sel == SEL_DST) dst[s] <= wdata & DST_WM;
        else                cfg[s] <= wdata & WM;
      end
    end
  end
endmodule

// File: rtl/ipr_gate.sv
module ipr_gate
  import ipr_pkg::*;
(
  input  logic [31:0] cfg,
  input  logic [31:0] dst,
  input  logic        act,
  input  logic        in_now,
  input  logic        in_prev,
  output logic        fire,
  output logic        act_drop
);
  logic elig;
  logic asrt;

  always_comb begin
    elig     = (in_now != in_prev) && !cfg[MASK_BIT]
               && (cfg[PRI_LSB +: PRI_W] != '0) && (dst != '0);
    asrt     = (in_now == cfg[POL_BIT]);
    fire     = elig && asrt && !act;
    act_drop = elig && !asrt && act && cfg[SENSE_BIT];
  end
endmodule

// File: rtl/ipr_cpu_route.sv
module ipr_cpu_route
  import ipr_pkg::*;
#(
  parameter int NSRC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRI_W-1:0] pri [NSRC],
  input  logic [NSRC-1:0]  fire,
  input  logic [NSRC-1:0]  tgt,
  input  logic [NSRC-1:0]  clr,
  input  logic [PRI_W-1:0] tpri,
  output logic [NSRC-1:0]  raised,
  output logic [NSRC-1:0]  deliver,
  output logic             irq
);
  logic [PRI_W-1:0] best;
  logic             outrank;

  always_comb begin
    best = '0;
    for (int s = 0; s < NSRC; s++)
      if (raised[s] && (pri[s] > best)) best = pri[s];
  end

  always_comb begin
    outrank = 1'b0;
    for (int s = 0; s < NSRC; s++) begin
      deliver[s] = fire[s] && tgt[s] && (pri[s] > tpri) && !raised[s];
      if (deliver[s] && (pri[s] > best)) outrank = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raised <= '0;
      irq    <= 1'b0;
    end else begin
      raised <= (raised & ~clr) | deliver;
      irq    <= outrank;
    end
  end
endmodule

// File: rtl/irq_src_router.sv
module irq_src_router
  import ipr_pkg::*;
#(
  parameter int NSRC      = 16,
  parameter int NCPU      = 2,
  parameter int FIRST_TMR = 12,
  localparam int SW       = $clog2(NSRC)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       irq_in,
  input  logic [NCPU*PRI_W-1:0] task_pri,
  input  logic                  reg_we,
  input  logic [SW-1:0]         reg_idx,
  input  logic                  reg_sel,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic [NSRC-1:0]       act_clr,
  input  logic [NCPU*NSRC-1:0]  raised_clr,
  output logic [NCPU*NSRC-1:0]  raised_o,
  output logic [NCPU-1:0]       cpu_irq
);
  logic [31:0]      cfg_w [NSRC];
  logic [31:0]      dst_w [NSRC];
  logic [PRI_W-1:0] pri   [NSRC];
  logic [NSRC-1:0]  act_q, prev_q, fire, act_drop, set_any;
  logic [NSRC-1:0]  tgt     [NCPU];
  logic [NSRC-1:0]  deliver [NCPU];

  ipr_src_regs #(.NSRC(NSRC), .NCPU(NCPU), .FIRST_TMR(FIRST_TMR)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .idx(reg_idx), .sel(reg_sel),
    .wdata(reg_wdata), .cfg(cfg_w), .dst(dst_w)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_gate
    assign pri[s] = cfg_w[s][PRI_LSB +: PRI_W];
    ipr_gate u_gate (
      .cfg(cfg_w[s]), .dst(dst_w[s]), .act(act_q[s]),
      .in_now(irq_in[s]), .in_prev(prev_q[s]),
      .fire(fire[s]), .act_drop(act_drop[s])
    );
  end

  always_comb begin
    set_any = '0;
    for (int c = 0; c < NCPU; c++) begin
      for (int s = 0; s < NSRC; s++) tgt[c][s] = dst_w[s][c];
      set_any = set_any | deliver[c];
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    ipr_cpu_route #(.NSRC(NSRC)) u_route (
      .clk(clk), .rst_n(rst_n), .pri(pri), .fire(fire), .tgt(tgt[c]),
      .clr(raised_clr[c*NSRC +: NSRC]), .tpri(task_pri[c*PRI_W +: PRI_W]),
      .raised(raised_o[c*NSRC +: NSRC]), .deliver(deliver[c]), .irq(cpu_irq[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      act_q  <= '0;
    end else begin
      prev_q <= irq_in;
      act_q  <= (act_q & ~act_clr & ~act_drop) | set_any;
    end
  end

  always_comb begin
    if (reg_sel == SEL_DST) reg_rdata = dst_w[reg_idx];
    else reg_rdata = cfg_w[reg_idx] | (32'(act_q[reg_idx]) << ACT_BIT);
  end
endmodule

// File: rtl/ipr_chk.sv
module ipr_chk
  import ipr_pkg::*;
#(
  parameter int NSRC = 16,
  parameter int NCPU = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NSRC-1:0]       irq_in,
  input logic [NSRC-1:0]       act_clr,
  input logic [NCPU*PRI_W-1:0] task_pri,
  input logic [NCPU*NSRC-1:0]  raised_o,
  input logic [NCPU-1:0]       cpu_irq,
  input logic [NSRC-1:0]       act,
  input logic [NSRC-1:0]       prev,
  input logic [31:0]           cfg [NSRC],
  input logic [31:0]           dst [NSRC]
);
  logic [NCPU*NSRC-1:0] raised_d;
  logic [NCPU*NSRC-1:0] newr;
  logic [NSRC-1:0]      newr_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raised_d <= '0;
    else        raised_d <= raised_o;
  end

  always_comb begin
    newr     = raised_o & ~raised_d;
    newr_src = '0;
    for (int c = 0; c < NCPU; c++) newr_src = newr_src | newr[c*NSRC +: NSRC];
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_c
    // R9
    irq_has_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq[c] |-> (newr[c*NSRC +: NSRC] != '0));

    for (genvar s = 0; s < NSRC; s++) begin : g_s
      // R5 R8
      deliver_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        newr[c*NSRC+s] |-> $past(!cfg[s][MASK_BIT] && dst[s][c] && (irq_in[s] != prev[s])
                                 && (cfg[s][PRI_LSB +: PRI_W] > task_pri[c*PRI_W +: PRI_W])));
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_a
    // R8
    act_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act[s]) |-> newr_src[s]);
    // R6
    act_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(act[s]) |-> ($past(act_clr[s]) || ($past(irq_in[s]) != $past(prev[s]))));
    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      newr_src[s] |-> !$past(act[s]));
  end
endmodule

bind irq_src_router ipr_chk #(.NSRC(NSRC), .NCPU(NCPU)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .act_clr(act_clr), .task_pri(task_pri),
  .raised_o(raised_o), .cpu_irq(cpu_irq), .act(act_q), .prev(prev_q),
  .cfg(cfg_w), .dst(dst_w)
);

// File: tb/sim_irq_src_router.sv
`timescale 1ns/1ps
module sim_irq_src_router;
  localparam int NSRC = 16, NCPU = 2, FT = 12, SW = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                 rst_n = 1'b0;
  logic [NSRC-1:0]      irq_in = '0;
  logic [NCPU*4-1:0]    task_pri = '0;
  logic                 reg_we = 1'b0;
  logic [SW-1:0]        reg_idx = '0;
  logic                 reg_sel = 1'b0;
  logic [31:0]          reg_wdata = '0;
  logic [31:0]          reg_rdata;
  logic [NSRC-1:0]      act_clr = '0;
  logic [NCPU*NSRC-1:0] raised_clr = '0;
  logic [NCPU*NSRC-1:0] raised_o;
  logic [NCPU-1:0]      cpu_irq;

  irq_src_router #(.NSRC(NSRC), .NCPU(NCPU), .FIRST_TMR(FT)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .task_pri(task_pri),
    .reg_we(reg_we), .reg_idx(reg_idx), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .act_clr(act_clr), .raised_clr(raised_clr),
    .raised_o(raised_o), .cpu_irq(cpu_irq)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  // behavioural reference model
  logic [31:0]          m_cfg [NSRC];
  logic [31:0]          m_dst [NSRC];
  logic [NSRC-1:0]      m_act, m_prev;
  logic [NCPU*NSRC-1:0] m_rs;
  logic [NCPU-1:0]      m_irq;

  always @(posedge clk) begin : mdl
    int best [NCPU];
    int p;
    logic [NCPU*NSRC-1:0] nr;
    logic [NSRC-1:0] na;
    logic [NCPU-1:0] ni;
    logic asrt;
    if (!rst_n) begin
      for (int s = 0; s < NSRC; s++) begin m_cfg[s] = 32'hA000_0000; m_dst[s] = 0; end
      m_act = 0; m_prev = 0; m_rs = 0; m_irq = 0;
    end else begin
      for (int c = 0; c < NCPU; c++) begin
        best[c] = 0;
        for (int s = 0; s < NSRC; s++)
          if (m_rs[c*NSRC+s] && int'(m_cfg[s][19:16]) > best[c]) best[c] = int'(m_cfg[s][19:16]);
      end
      nr = m_rs & ~raised_clr;
      na = m_act & ~act_clr;
      ni = 0;
      for (int s = 0; s < NSRC; s++) begin
        p = int'(m_cfg[s][19:16]);
        asrt = (irq_in[s] == m_cfg[s][23]);
        if (irq_in[s] != m_prev[s] && !m_cfg[s][31] && p != 0 && m_dst[s] != 0) begin
          if (!asrt) begin
            if (m_act[s] && m_cfg[s][22]) na[s] = 1'b0;
          end else if (!m_act[s]) begin
            for (int c = 0; c < NCPU; c++)
              if (m_dst[s][c] && p > int'(task_pri[c*4 +: 4]) && !m_rs[c*NSRC+s]) begin
                nr[c*NSRC+s] = 1'b1;
                na[s] = 1'b1;
                if (p > best[c]) ni[c] = 1'b1;
              end
          end
        end
      end
      if (reg_we) begin
        if (reg_sel) m_dst[reg_idx] = reg_wdata & 32'hC000_0003;
        else m_cfg[reg_idx] = reg_wdata & (32'h800F_00FF |
                              ((int'(reg_idx) >= FT) ? 32'h00F0_0000 : 32'h00C0_0000));
      end
      m_rs = nr; m_act = na; m_irq = ni; m_prev = irq_in;
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R8 model raised", raised_o, m_rs);
      chk("R9 model irq", 32'(cpu_irq), 32'(m_irq));
      chk("R2 model read", reg_rdata, reg_sel ? m_dst[reg_idx]
                                     : (m_cfg[reg_idx] | (32'(m_act[reg_idx]) << 30)));
    end
  end

  task automatic summary();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      fails++;
      $display("FAIL watchdog got=%0d exp=<5000", cyc);
      summary();
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int s, bit sel, logic [31:0] d);
    reg_we = 1; reg_idx = SW'(s); reg_sel = sel; reg_wdata = d;
    tick();
    reg_we = 0;
  endtask

  task automatic rd(int s, bit sel, output logic [31:0] v);
    reg_idx = SW'(s); reg_sel = sel;
    #1 v = reg_rdata;
  endtask

  logic [31:0] v;

  initial begin
    tick(3);
    rst_n = 1;
    tick();
    // R1
    rd(0, 0, v); chk("R1 cfg reset", v, 32'hA000_0000);
    rd(5, 1, v); chk("R1 dst reset", v, 0);
    chk("R1 raised reset", raised_o, 0);
    chk("R1 irq reset", 32'(cpu_irq), 0);
    // R2 R3
    wr(0, 0, 32'hFFFF_FFFF); rd(0, 0, v); chk("R2 ext write mask", v, 32'h80CF_00FF);
    wr(13, 0, 32'hFFFF_FFFF); rd(13, 0, v); chk("R2 timer write mask", v, 32'h80FF_00FF);
    wr(0, 1, 32'hFFFF_FFFF); rd(0, 1, v); chk("R3 dst write mask", v, 32'hC000_0003);
    // R4 R8 R9: edge, active high, prio 5, cpu0
    task_pri = {4'd3, 4'd3};
    wr(1, 0, 32'h0085_0021); wr(1, 1, 1);
    irq_in[1] = 1; tick();
    chk("R8 deliver", raised_o, 32'h0000_0002);
    chk("R9 irq pulse", 32'(cpu_irq), 1);
    rd(1, 0, v); chk("R8 activity set", v, 32'h4085_0021);
    tick(); chk("R9 pulse one cycle", 32'(cpu_irq), 0);
    // R6 edge deassert
    irq_in[1] = 0; tick();
    rd(1, 0, v); chk("R6 edge deassert", v, 32'h4085_0021);
    // R7
    irq_in[1] = 1; tick();
    chk("R7 busy ignored", 32'(cpu_irq), 0);
    // R10 activity clear, then re-raise blocked by pending bit
    act_clr[1] = 1; tick(); act_clr[1] = 0;
    rd(1, 0, v); chk("R10 act clear", v, 32'h0085_0021);
    irq_in[1] = 0; tick(); irq_in[1] = 1; tick();
    rd(1, 0, v); chk("R8 no accept no activity", v, 32'h0085_0021);
    // R5
    wr(2, 0, 32'h8085_0022); wr(2, 1, 1); irq_in[2] = 1; tick();
    wr(3, 0, 32'h0080_0000); wr(3, 1, 1); irq_in[3] = 1; tick();
    wr(4, 0, 32'h0085_0000); irq_in[4] = 1; tick();
    chk("R5 ignored sources", raised_o, 32'h0000_0002);
    rd(2, 0, v); chk("R5 masked no activity", v, 32'h8085_0022);
    // R8 strict compare
    wr(5, 0, 32'h0083_0025); wr(5, 1, 1); irq_in[5] = 1; tick();
    chk("R8 equal priority refused", raised_o, 32'h0000_0002);
    task_pri = {4'd3, 4'd2};
    irq_in[5] = 0; tick(); irq_in[5] = 1; tick();
    chk("R8 above task pri", raised_o, 32'h0000_0022);
    chk("R9 no outrank", 32'(cpu_irq), 0);
    // R6 level, two cpus
    task_pri = 0;
    wr(6, 0, 32'h00C7_0026); wr(6, 1, 3); irq_in[6] = 1; tick();
    chk("R8 both cpus", raised_o, 32'h0040_0062);
    chk("R9 both pulse", 32'(cpu_irq), 3);
    irq_in[6] = 0; tick();
    rd(6, 0, v); chk("R6 level deassert", v, 32'h00C7_0026);
    chk("R6 pending kept", raised_o, 32'h0040_0062);
    // R4 active low
    wr(7, 0, 32'h0005_0027); wr(7, 1, 2);
    irq_in[7] = 1; tick();
    chk("R4 active low release", raised_o, 32'h0040_0062);
    irq_in[7] = 0; tick();
    chk("R4 active low assert", raised_o, 32'h00C0_0062);
    chk("R9 lower than pending", 32'(cpu_irq), 0);
    // R11
    wr(8, 0, 32'h0084_0028); wr(8, 1, 1);
    reg_we = 1; reg_idx = 8; reg_sel = 0; reg_wdata = 32'h8084_0028; irq_in[8] = 1;
    tick(); reg_we = 0;
    chk("R11 old config used", raised_o, 32'h00C0_0162);
    rd(8, 0, v); chk("R11 write landed", v, 32'hC084_0028);
    // R10 pending clear and delivery precedence
    raised_clr = 32'h0000_0002; tick(); raised_clr = 0;
    chk("R10 raised clear", raised_o, 32'h00C0_0160);
    wr(9, 0, 32'h0089_0029); wr(9, 1, 1);
    raised_clr = 32'h0000_0200; irq_in[9] = 1; tick(); raised_clr = 0;
    chk("R10 delivery wins", raised_o, 32'h00C0_0360);
    chk("R9 outrank pulse", 32'(cpu_irq), 1);
    tick(3);
    summary();
  end
endmodule